// File: doc/BRIEF.md
# Three-in-a-row ones detector

This block watches a one-bit serial stream. It takes one sample on every rising clock edge and flags when the stream has held 1 for three or more samples in a row. A two-bit state register tracks the length of the current run of ones, and the count stops rising once it reaches three. The flag is a Mealy output. It is formed combinationally from the stored state and the live input bit, so it rises during the same cycle that the third 1 is presented. It stays high for each further 1 and drops as soon as the input shows 0.

The stream has no handshake and cannot be stalled. The block accepts one bit every cycle and never pushes back. A source that cannot keep up has to supply a filler value itself. A 0 ends the run.

The four states are: no ones seen, one 1, two 1s, and three or more 1s. They are encoded 00, 01, 10 and 11. A synchronous active-high reset returns the state to "no ones seen".

Top module: `run3_detector`

## Requirements
- R1: While `rst` is 1, `hit` is 0 whatever `din` is. A rising edge with `rst` at 1 returns the state to "no ones seen" (code 00), so three new 1s are needed after reset before `hit` rises.
- R2: A `din` of 0 gives `hit` = 0 in that cycle, and the next edge returns the state to "no ones seen" (code 00).
- R3: The first and second consecutive 1s give `hit` = 0. These are the first two after reset or after a 0, and they move the state 00 to 01 and 01 to 10.
- R4: The third consecutive 1 gives `hit` = 1 in the same cycle that it is presented, with no added edge, and moves the state to 11.
- R5: Every further consecutive 1 gives `hit` = 1, and the state stays at 11.
- R6: `hit` follows `din` within a cycle. When the state is 11, changing `din` between edges changes `hit` immediately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample of `din` per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial input bit |
| hit | output | 1 | High while the current run of ones is three or longer |

## Verification
`hit` is due zero cycles after `din` changes, because it depends only on the stored state and the present bit. The effect of a bit on the state shows up only after the next rising edge. The bench changes `din` and `rst` on the falling edge and samples `hit` 1 ns later, in the same low phase. Its reference run counter advances only after the following rising edge, so each comparison uses exactly the history the design has registered. The R6 check changes `din` twice inside one low phase and samples after each change, with no edge in between.

// File: rtl/r3d_pkg.sv
package r3d_pkg;
  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_NONE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b10,
    ST_RUN  = 2'b11
  } run_st_e;
endpackage

// File: rtl/r3d_next.sv
module r3d_next
  import r3d_pkg::*;
(
  input  run_st_e cur,
  input  logic    din,
  output run_st_e nxt
);
  logic hi_bit;
  logic lo_bit;

  // upper bit: a 1 arriving after at least one 1
  // lower bit: a 1 arriving in any state except "one seen"
  always_comb begin
    hi_bit = din & (cur[1] | cur[0]);
    lo_bit = din & (cur[1] | ~cur[0]);
    nxt    = run_st_e'({hi_bit, lo_bit});
  end
endmodule

// File: rtl/r3d_state_reg.sv
module r3d_state_reg
  import r3d_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  run_st_e nxt,
  output run_st_e cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= ST_NONE;
    else     cur <= nxt;
  end
endmodule

// File: rtl/r3d_out.sv
module r3d_out
  import r3d_pkg::*;
(
  input  run_st_e cur,
  input  logic    din,
  input  logic    rst,
  output logic    hit
);
  // Mealy flag: upper state bit qualified by the live input bit
  assign hit = din & cur[1] & ~rst;
endmodule

// File: rtl/run3_detector.sv
module run3_detector
  import r3d_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  run_st_e st_q;
  run_st_e st_d;

  r3d_next u_next (
    .cur (st_q),
    .din (din),
    .nxt (st_d)
  );

  r3d_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (st_d),
    .cur (st_q)
  );

  r3d_out u_out (
    .cur (st_q),
    .din (din),
    .rst (rst),
    .hit (hit)
  );
endmodule

// File: rtl/r3d_checker.sv
module r3d_checker
  import r3d_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    din,
  input logic    hit,
  input run_st_e st
);
  logic rst_d = 1'b0;

  always_ff @(posedge clk) rst_d <= rst;

  // R1: flag quiet during reset, state cleared after a reset edge
  always @(negedge clk) begin
    if (rst === 1'b1) begin
      p_quiet_in_reset_r1: assert (hit == 1'b0);
    end
    if (rst_d === 1'b1) begin
      p_cleared_by_reset_r1: assert (st == ST_NONE);
    end
  end

  // R2: a zero clears the run
  p_zero_clears_r2: assert property (@(posedge clk) disable iff (rst)
    !din |=> st == ST_NONE);

  // R3: first one leaves the idle state for the one-seen state
  p_first_step_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_NONE && din) |=> st == ST_ONE);

  // R4: three ones in a row with no reset in between raise the flag
  p_third_one_r4: assert property (@(posedge clk) disable iff (rst)
    (din && $past(din) && $past(din, 2) && !$past(rst) && !$past(rst, 2)) |-> hit);

  // R4/R5: the flag never rises without two prior ones
  p_hit_has_history_r5: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(din) && $past(din, 2)));

  // R6: no flag on a zero sample
  p_no_hit_on_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !din |-> !hit);
endmodule

bind run3_detector r3d_checker u_chk (
  .clk (clk),
  .rst (rst),
  .din (din),
  .hit (hit),
  .st  (st_q)
);

// File: tb/sim_run3_detector.sv
`timescale 1ns/1ps
module sim_run3_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;

  int checks   = 0;
  int failures = 0;
  int run      = 0;   // reference run length, saturates at 3
  bit done     = 0;

  always #5 clk = ~clk;

  run3_detector u0 (
    .clk (clk),
    .rst (rst),
    .din (din),
    .hit (hit)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (hit !== exp) begin
      failures++;
      $display("FAIL %s: hit=%b expected=%b (run=%0d rst=%b din=%b) at %0t",
               req, hit, exp, run, rst, din, $time);
    end
  endtask

  // one cycle: drive at falling edge, compare 1 ns later, advance model at rising edge
  task automatic step(input logic r, input logic d);
    string req;
    logic  exp;
    @(negedge clk);
    rst = r;
    din = d;
    #1;
    exp = !r && d && (run >= 2);
    if (r)            req = "R1";
    else if (!d)      req = "R2";
    else if (run < 2) req = "R3";
    else if (run == 2) req = "R4";
    else              req = "R5";
    check(exp, req);
    @(posedge clk);
    if (r)       run = 0;
    else if (d)  run = (run < 3) ? run + 1 : 3;
    else         run = 0;
  endtask

  task automatic send(input string bits);
    for (int i = 0; i < bits.len(); i++) step(1'b0, bits[i] == "1");
  endtask

  initial begin
    // R1: reset with din high must keep hit low
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    // R3 R4 R5 R2: directed pattern
    send("0111101");
    // long run, R5
    send("0");
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1);
    // R2: single and double ones broken by zeros
    send("0110101101110");
    // R1: reset in the middle of a saturated run
    send("1111");
    step(1'b1, 1'b1);
    send("1110");
    // R6: toggle din within one low phase while in the saturated state
    send("111");
    @(negedge clk);
    din = 1'b0;
    #1;
    checks++;
    if (hit !== 1'b0) begin
      failures++;
      $display("FAIL R6: hit=%b expected=0 after din fell", hit);
    end
    din = 1'b1;
    #1;
    checks++;
    if (hit !== 1'b1) begin
      failures++;
      $display("FAIL R6: hit=%b expected=1 after din rose", hit);
    end
    @(posedge clk);
    run = 3;
    // random streams with occasional reset
    for (int i = 0; i < 3000; i++)
      step(($urandom_range(0, 99) == 0), ($urandom_range(0, 3) != 0));
    for (int i = 0; i < 2000; i++)
      step(1'b0, $urandom_range(0, 1) == 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule